// File: doc/BRIEF.md
# Idle-Gated Memory Access Window

This block sits between a host bus and the two private memories of a coprocessor: an instruction memory and a data memory. It decodes each host read or write into one of two fixed byte windows. The instruction window starts at 0x4000 and the data window starts at 0x8000, and each window spans 16 KiB. A decoded access goes to a word-wide memory port only while the coprocessor reports that it is idle.

A busy coprocessor must not be disturbed. A host access made while it is busy gets no memory traffic, returns zero, and raises a one-cycle illegal-access strobe that the surrounding logic treats as fatal. A locked coprocessor also gets no memory traffic and returns zero, but no strobe is raised. The data memory is 4 KB deep, but only its lower 3 KB can be reached from the bus. The top kilobyte is private scratch space. Bus addresses that would reach that scratch space, addresses in the unused part of either window, and addresses outside both windows get an error response and change nothing.

Every host access receives exactly one response, one cycle later. The response carries a valid strobe, read data, the error flag and the illegal-access strobe. The memories take an address in one cycle and deliver read data on the next.

Top module: `memwin_gate`

## Requirements
- R1: With the coprocessor idle (state code 0), an access to byte address 0x4000..0x4FFF asserts `imem_req` in the same cycle. The port carries word index (address − 0x4000) >> 2, `imem_we` equal to the write strobe, and the host write data.
- R2: With the coprocessor idle, an access to byte address 0x8000..0x8BFF asserts `dmem_req` in the same cycle. The port carries word index (address − 0x8000) >> 2, `dmem_we` equal to the write strobe, and the host write data.
- R3: An access to 0x8C00..0x8FFF (data scratch), to 0x5000..0x7FFF or 0x9000..0xBFFF (unused window space), or to any address outside 0x4000..0xBFFF raises no memory request. Its response has `rsp_err`=1 and read data zero.
- R4: Each cycle with a read or write strobe yields `rsp_valid`=1 in the following cycle. A cycle without a strobe yields `rsp_valid`=0 in the following cycle.
- R5: With the coprocessor busy (state code 1), an access raises no memory request and returns read data zero. It also pulses `illegal_access` in the response cycle, whether or not the address decodes.
- R6: With the coprocessor locked (state code 2 or 3), an access raises no memory request and returns read data zero, with `illegal_access`=0. A write made while locked leaves memory unchanged, which a later idle read shows.
- R7: After a synchronous reset, `rsp_valid`, `rsp_err`, `illegal_access` and `rsp_rdata` are all zero.
- R8: A forwarded idle write gets a response with read data zero. The word it wrote is returned by a later idle read of the same address.
- R9: The two low address bits are ignored. Every access is a full 32-bit word and there are no byte enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 16 | Host byte address |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe (wins over read) |
| host_wdata | input | 32 | Host write word |
| cop_state | input | 2 | 0 idle, 1 busy, 2 or 3 locked |
| imem_req | output | 1 | Instruction memory request |
| imem_we | output | 1 | Instruction memory write enable |
| imem_addr | output | 10 | Instruction memory word index |
| imem_wdata | output | 32 | Instruction memory write word |
| imem_rdata | input | 32 | Instruction memory read word, one cycle after request |
| dmem_req | output | 1 | Data memory request |
| dmem_we | output | 1 | Data memory write enable |
| dmem_addr | output | 10 | Data memory word index |
| dmem_wdata | output | 32 | Data memory write word |
| dmem_rdata | input | 32 | Data memory read word, one cycle after request |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 32 | Response read data |
| rsp_err | output | 1 | Address hit no implemented word |
| illegal_access | output | 1 | Access attempted while busy |

## Verification
The bench drives accesses at the edges of every region: the first and last word of each window, the first scratch word, and the first and last byte of the unused space. A decoder that is off by one word would leak a request into scratch or reject the last legal word. Busy and locked accesses are aimed at words that already hold known data, so a gate that still forwarded them would corrupt words that a later idle read exposes. A mixed-up state decode would show the strobe on the wrong one of the two states. Unaligned addresses and random mixes of state, strobe and region are compared every cycle against a behavioural model. That comparison catches a response that comes out a cycle late or carries data from the wrong memory.

// File: rtl/memwin_pkg.sv
package memwin_pkg;

    // Host byte address width and derived word index width.
    localparam int ADDR_W = 16;
    localparam int BYTES_PER_WORD = 4;

    // Coprocessor state codes seen on cop_state.
    typedef enum logic [1:0] {
        COP_IDLE    = 2'd0,
        COP_BUSY    = 2'd1,
        COP_LOCKED  = 2'd2,
        COP_LOCKED2 = 2'd3
    } cop_state_e;

    // Destination of a decoded access.
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_IMEM = 2'd1,
        TGT_DMEM = 2'd2
    } tgt_e;

    // Decode result carried from the decoder to the gate.
    typedef struct packed {
        tgt_e tgt;      // implemented word hit
        logic hole;     // inside a window span but no implemented word
        logic outside;  // in no window span
    } dec_t;

    // True when a byte offset lies in [0, lim).
    function automatic logic off_below(input int off, input int lim);
        return (off >= 0) && (off < lim);
    endfunction

    // Busy states raise the illegal-access strobe.
    function automatic logic is_busy(input logic [1:0] st);
        return cop_state_e'(st) == COP_BUSY;
    endfunction

    function automatic logic is_idle(input logic [1:0] st);
        return cop_state_e'(st) == COP_IDLE;
    endfunction

endpackage

// File: rtl/memwin_decode.sv
module memwin_decode
    import memwin_pkg::*;
#(
    parameter int IMEM_BASE      = 'h4000,
    parameter int DMEM_BASE      = 'h8000,
    parameter int WIN_SPAN       = 'h4000,
    parameter int IMEM_WORDS     = 1024,
    parameter int DMEM_VIS_WORDS = 768,
    parameter int IMEM_AW        = 10,
    parameter int DMEM_AW        = 10
) (
    input  logic [ADDR_W-1:0]  addr,
    output dec_t               dec,
    output logic [IMEM_AW-1:0] imem_idx,
    output logic [DMEM_AW-1:0] dmem_idx
);

    localparam int IMEM_BYTES = IMEM_WORDS * BYTES_PER_WORD;
    localparam int DMEM_BYTES = DMEM_VIS_WORDS * BYTES_PER_WORD;

    int   ioff;
    int   doff;
    logic i_span, d_span, i_impl, d_impl;

    assign ioff = int'(addr) - IMEM_BASE;
    assign doff = int'(addr) - DMEM_BASE;

    assign i_span = off_below(ioff, WIN_SPAN);
    assign d_span = off_below(doff, WIN_SPAN);
    assign i_impl = off_below(ioff, IMEM_BYTES);
    assign d_impl = off_below(doff, DMEM_BYTES);

    // Word index drops the byte-lane bits; they never reach memory.
    assign imem_idx = IMEM_AW'(ioff >>> 2);
    assign dmem_idx = DMEM_AW'(doff >>> 2);

    always_comb begin
        dec.tgt = TGT_NONE;
        if (i_impl) begin
            dec.tgt = TGT_IMEM;
        end else if (d_impl) begin
            dec.tgt = TGT_DMEM;
        end
        dec.hole    = (i_span && !i_impl) || (d_span && !d_impl);
        dec.outside = !i_span && !d_span;
    end

endmodule

// File: rtl/memwin_access_gate.sv
module memwin_access_gate
    import memwin_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMEM_AW = 10,
    parameter int DMEM_AW = 10
) (
    input  logic               access,
    input  logic               wr,
    input  logic [1:0]         state,
    input  dec_t               dec,
    input  logic [IMEM_AW-1:0] imem_idx,
    input  logic [DMEM_AW-1:0] dmem_idx,
    input  logic [DATA_W-1:0]  wdata,
    output logic               imem_req,
    output logic               imem_we,
    output logic [IMEM_AW-1:0] imem_addr,
    output logic [DATA_W-1:0]  imem_wdata,
    output logic               dmem_req,
    output logic               dmem_we,
    output logic [DMEM_AW-1:0] dmem_addr,
    output logic [DATA_W-1:0]  dmem_wdata,
    output tgt_e               rd_src,
    output logic               err_now,
    output logic               illegal_now
);

    logic fwd;

    // Only an idle coprocessor lets a decoded access through.
    assign fwd = access && is_idle(state) && (dec.tgt != TGT_NONE);

    assign imem_req   = fwd && (dec.tgt == TGT_IMEM);
    assign imem_we    = imem_req && wr;
    assign imem_addr  = imem_idx;
    assign imem_wdata = wdata;

    assign dmem_req   = fwd && (dec.tgt == TGT_DMEM);
    assign dmem_we    = dmem_req && wr;
    assign dmem_addr  = dmem_idx;
    assign dmem_wdata = wdata;

    // Forwarded reads name the memory whose data comes back next cycle.
    assign rd_src      = (fwd && !wr) ? dec.tgt : TGT_NONE;
    assign err_now     = access && (dec.hole || dec.outside);
    assign illegal_now = access && is_busy(state);

endmodule

// File: rtl/memwin_rsp_stage.sv
module memwin_rsp_stage
    import memwin_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              access,
    input  tgt_e              rd_src,
    input  logic              err_now,
    input  logic              illegal_now,
    input  logic [DATA_W-1:0] imem_rdata,
    input  logic [DATA_W-1:0] dmem_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              illegal_access
);

    tgt_e src_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid      <= 1'b0;
            rsp_err        <= 1'b0;
            illegal_access <= 1'b0;
            src_q          <= TGT_NONE;
        end else begin
            rsp_valid      <= access;
            rsp_err        <= err_now;
            illegal_access <= illegal_now;
            src_q          <= rd_src;
        end
    end

    // Memory data arrives in the response cycle; anything else is zero.
    always_comb begin
        unique case (src_q)
            TGT_IMEM: rsp_rdata = imem_rdata;
            TGT_DMEM: rsp_rdata = dmem_rdata;
            default:  rsp_rdata = '0;
        endcase
    end

    // R4
    rsp_follows_chk: assert property (@(posedge clk) disable iff (rst)
        access |=> rsp_valid);

    // R4
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !access |=> !rsp_valid && !rsp_err && !illegal_access);

endmodule

// File: rtl/memwin_gate.sv
module memwin_gate
    import memwin_pkg::*;
#(
    parameter int  DATA_W         = 32,
    parameter int  IMEM_BASE      = 'h4000,
    parameter int  DMEM_BASE      = 'h8000,
    parameter int  WIN_SPAN       = 'h4000,
    parameter int  IMEM_WORDS     = 1024,
    parameter int  DMEM_WORDS     = 1024,
    parameter int  DMEM_VIS_WORDS = 768,
    localparam int IMEM_AW        = $clog2(IMEM_WORDS),
    localparam int DMEM_AW        = $clog2(DMEM_WORDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic               host_rd,
    input  logic               host_wr,
    input  logic [DATA_W-1:0]  host_wdata,
    input  logic [1:0]         cop_state,
    output logic               imem_req,
    output logic               imem_we,
    output logic [IMEM_AW-1:0] imem_addr,
    output logic [DATA_W-1:0]  imem_wdata,
    input  logic [DATA_W-1:0]  imem_rdata,
    output logic               dmem_req,
    output logic               dmem_we,
    output logic [DMEM_AW-1:0] dmem_addr,
    output logic [DATA_W-1:0]  dmem_wdata,
    input  logic [DATA_W-1:0]  dmem_rdata,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               rsp_err,
    output logic               illegal_access
);

    localparam int SCR_LO = DMEM_BASE + DMEM_VIS_WORDS * BYTES_PER_WORD;
    localparam int SCR_HI = DMEM_BASE + DMEM_WORDS * BYTES_PER_WORD;

    logic               access;
    dec_t               dec;
    logic [IMEM_AW-1:0] imem_idx;
    logic [DMEM_AW-1:0] dmem_idx;
    tgt_e               rd_src;
    logic               err_now;
    logic               illegal_now;

    assign access = host_rd || host_wr;

    memwin_decode #(
        .IMEM_BASE      (IMEM_BASE),
        .DMEM_BASE      (DMEM_BASE),
        .WIN_SPAN       (WIN_SPAN),
        .IMEM_WORDS     (IMEM_WORDS),
        .DMEM_VIS_WORDS (DMEM_VIS_WORDS),
        .IMEM_AW        (IMEM_AW),
        .DMEM_AW        (DMEM_AW)
    ) u_decode (
        .addr     (host_addr),
        .dec      (dec),
        .imem_idx (imem_idx),
        .dmem_idx (dmem_idx)
    );

    memwin_access_gate #(
        .DATA_W  (DATA_W),
        .IMEM_AW (IMEM_AW),
        .DMEM_AW (DMEM_AW)
    ) u_gate (
        .access      (access),
        .wr          (host_wr),
        .state       (cop_state),
        .dec         (dec),
        .imem_idx    (imem_idx),
        .dmem_idx    (dmem_idx),
        .wdata       (host_wdata),
        .imem_req    (imem_req),
        .imem_we     (imem_we),
        .imem_addr   (imem_addr),
        .imem_wdata  (imem_wdata),
        .dmem_req    (dmem_req),
        .dmem_we     (dmem_we),
        .dmem_addr   (dmem_addr),
        .dmem_wdata  (dmem_wdata),
        .rd_src      (rd_src),
        .err_now     (err_now),
        .illegal_now (illegal_now)
    );

    memwin_rsp_stage #(
        .DATA_W (DATA_W)
    ) u_rsp (
        .clk            (clk),
        .rst            (rst),
        .access         (access),
        .rd_src         (rd_src),
        .err_now        (err_now),
        .illegal_now    (illegal_now),
        .imem_rdata     (imem_rdata),
        .dmem_rdata     (dmem_rdata),
        .rsp_valid      (rsp_valid),
        .rsp_rdata      (rsp_rdata),
        .rsp_err        (rsp_err),
        .illegal_access (illegal_access)
    );

    // R5
    busy_no_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (cop_state == COP_BUSY) |-> !imem_req && !dmem_req);

    // R5
    busy_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (access && cop_state == COP_BUSY) |=> illegal_access && rsp_rdata == '0);

    // R6
    locked_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (access && cop_state[1]) |=> !illegal_access && rsp_rdata == '0);

    // R3
    scratch_unreached_chk: assert property (@(posedge clk) disable iff (rst)
        (access && int'(host_addr) >= SCR_LO && int'(host_addr) < SCR_HI)
        |-> !dmem_req && !imem_req);

    // R8
    write_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
        host_wr |=> rsp_rdata == '0);

    // R1
    one_port_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({imem_req, dmem_req}));

endmodule

// File: tb/memwin_gate_test.sv
module memwin_gate_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] host_addr;
    logic        host_rd, host_wr;
    logic [31:0] host_wdata;
    logic [1:0]  cop_state;
    logic        imem_req, imem_we, dmem_req, dmem_we;
    logic [9:0]  imem_addr, dmem_addr;
    logic [31:0] imem_wdata, dmem_wdata;
    logic [31:0] imem_rdata, dmem_rdata;
    logic        rsp_valid, rsp_err, illegal_access;
    logic [31:0] rsp_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    memwin_gate uut (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .cop_state(cop_state),
        .imem_req(imem_req), .imem_we(imem_we), .imem_addr(imem_addr),
        .imem_wdata(imem_wdata), .imem_rdata(imem_rdata),
        .dmem_req(dmem_req), .dmem_we(dmem_we), .dmem_addr(dmem_addr),
        .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .illegal_access(illegal_access)
    );

    // Bench-side memories behind the ports: one-cycle read latency.
    logic [31:0] bimem [1024];
    logic [31:0] bdmem [1024];
    // Reference copies kept by the behavioural model from host semantics.
    logic [31:0] rimem [1024];
    logic [31:0] rdmem [1024];

    always @(posedge clk) begin
        if (imem_req) begin
            if (imem_we) bimem[imem_addr] <= imem_wdata;
            else imem_rdata <= bimem[imem_addr];
        end
        if (dmem_req) begin
            if (dmem_we) bdmem[dmem_addr] <= dmem_wdata;
            else dmem_rdata <= bdmem[dmem_addr];
        end
    end

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h (cycle %0d)",
                     tag, what, act, exp, cyc);
        end
    endtask

    // Pending response expected in the next cycle.
    logic        p_valid = 0, p_err = 0, p_ill = 0;
    logic [31:0] p_rdata = 0;
    string       p_tag = "R7";

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_bad++;
            $display("FAIL R4 watchdog actual=%0d expected<%0d", cyc, 100000);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (cyc > 0) begin
            int    a, kind, idx;
            logic  acc, idle, busy;
            logic  e_i, e_d;
            string tag;
            // Response side, predicted one cycle ago.
            chk("R4", "rsp_valid", rsp_valid, p_valid);
            chk(p_tag, "rsp_rdata", rsp_rdata, p_rdata);
            chk(p_tag, "rsp_err", rsp_err, p_err);
            chk(p_tag, "illegal_access", illegal_access, p_ill);

            // Classify the current request.
            a = int'(host_addr);
            acc = host_rd || host_wr;
            idle = (cop_state == 2'd0);
            busy = (cop_state == 2'd1);
            if (a >= 'h4000 && a < 'h5000) begin kind = 1; idx = (a - 'h4000) / 4; end
            else if (a >= 'h8000 && a < 'h8C00) begin kind = 2; idx = (a - 'h8000) / 4; end
            else begin kind = 0; idx = 0; end

            if (rst) tag = "R7";
            else if (!acc) tag = "R4";
            else if (busy) tag = "R5";
            else if (!idle) tag = "R6";
            else if (kind == 0) tag = "R3";
            else if (host_wr) tag = "R8";
            else if (host_addr[1:0] != 2'b00) tag = "R9";
            else if (kind == 1) tag = "R1";
            else tag = "R2";

            e_i = !rst && acc && idle && kind == 1;
            e_d = !rst && acc && idle && kind == 2;
            chk(tag, "imem_req", imem_req, e_i);
            chk(tag, "dmem_req", dmem_req, e_d);
            if (e_i) begin
                chk(tag, "imem_we", imem_we, host_wr);
                chk(tag, "imem_addr", imem_addr, idx);
                if (host_wr) chk(tag, "imem_wdata", imem_wdata, host_wdata);
            end
            if (e_d) begin
                chk(tag, "dmem_we", dmem_we, host_wr);
                chk(tag, "dmem_addr", dmem_addr, idx);
                if (host_wr) chk(tag, "dmem_wdata", dmem_wdata, host_wdata);
            end

            // Next-cycle prediction and reference memory update.
            p_tag   = tag;
            p_valid = !rst && acc;
            p_err   = !rst && acc && kind == 0;
            p_ill   = !rst && acc && busy;
            p_rdata = 0;
            if (e_i && !host_wr) p_rdata = rimem[idx];
            if (e_d && !host_wr) p_rdata = rdmem[idx];
            if (e_i && host_wr) rimem[idx] = host_wdata;
            if (e_d && host_wr) rdmem[idx] = host_wdata;
        end
    end

    task automatic op(input logic [1:0] st, input logic rd, input logic wr,
                      input int addr, input logic [31:0] d);
        @(posedge clk);
        #1;
        cop_state  = st;
        host_rd    = rd;
        host_wr    = wr;
        host_addr  = 16'(addr);
        host_wdata = d;
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            bimem[i] = 0; bdmem[i] = 0; rimem[i] = 0; rdmem[i] = 0;
        end
        imem_rdata = 0; dmem_rdata = 0;
        rst = 1; host_addr = 0; host_rd = 0; host_wr = 0;
        host_wdata = 0; cop_state = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R7 reset state is compared by the model on the cycles above.
        // R1 first and last instruction words, R8 write responses.
        op(0, 0, 1, 'h4000, 32'hA1A1_0001);
        op(0, 0, 1, 'h4FFC, 32'hA1A1_03FF);
        op(0, 1, 0, 'h4000, 0);
        op(0, 1, 0, 'h4FFF, 0);              // R9 low bits ignored
        // R2 data window edges.
        op(0, 0, 1, 'h8000, 32'hD0D0_0000);
        op(0, 0, 1, 'h8BFC, 32'hD0D0_02FF);
        op(0, 1, 0, 'h8BFD, 0);              // R9
        op(0, 1, 0, 'h8000, 0);
        // R3 scratch, holes and outside addresses.
        op(0, 0, 1, 'h8C00, 32'hBAD0_0001);
        op(0, 0, 1, 'h8FFC, 32'hBAD0_0002);
        op(0, 1, 0, 'h5000, 0);
        op(0, 1, 0, 'h7FFF, 0);
        op(0, 1, 0, 'h9000, 0);
        op(0, 1, 0, 'hBFFC, 0);
        op(0, 1, 0, 'h0010, 0);
        op(0, 1, 0, 'hC000, 0);
        // R5 busy: blanked and flagged, including a miss address.
        op(1, 1, 0, 'h4000, 0);
        op(1, 0, 1, 'h4000, 32'hEEEE_0001);
        op(1, 0, 1, 'h8000, 32'hEEEE_0002);
        op(1, 1, 0, 'h9000, 0);
        // R6 locked with both codes.
        op(2, 1, 0, 'h4000, 0);
        op(2, 0, 1, 'h8BFC, 32'hEEEE_0003);
        op(3, 0, 1, 'h4FFC, 32'hEEEE_0004);
        op(3, 1, 0, 'h8000, 0);
        // Words untouched by blanked writes (R5, R6).
        op(0, 1, 0, 'h4000, 0);
        op(0, 1, 0, 'h8000, 0);
        op(0, 1, 0, 'h8BFC, 0);
        op(0, 1, 0, 'h4FFC, 0);
        op(0, 0, 0, 0, 0);
        // Random mix over all regions and states.
        for (int i = 0; i < 600; i++) begin
            int k, ad;
            logic [1:0] st;
            logic rd, wr;
            k = $urandom_range(0, 7);
            case (k)
                0, 1, 2: ad = 'h4000 + $urandom_range(0, 'hFFF);
                3, 4:    ad = 'h8000 + $urandom_range(0, 'hBFF);
                5:       ad = 'h8C00 + $urandom_range(0, 'h3FF);
                6:       ad = 'h5000 + $urandom_range(0, 'h2FFF);
                default: ad = $urandom_range(0, 'hFFFF);
            endcase
            st = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
            wr = $urandom_range(0, 2) == 0;
            rd = !wr && ($urandom_range(0, 4) != 0);
            op(st, rd, wr, ad, $urandom);
        end
        op(0, 0, 0, 0, 0);
        repeat (3) @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule